// File: doc/BRIEF.md
# Double-Buffered PWM Channel Core

This block drives one pulse-width-modulated output from two counts. The period count sets how many count steps make up one period. The duty count sets how many of those steps, at the start of each period, hold the output at its inactive level. The remaining steps of the period drive the active level. A power-of-two prescaler sets how many clock cycles one count step lasts. A polarity input chooses whether the active level is high or low.

While the channel is stopped, software-side logic can load the duty and period counts directly. While the channel runs, new values go into update buffers instead. A buffered value reaches the live counts only at the next period boundary, so the output never shows a partial period. Starting the channel also counts as a boundary.

A build parameter selects between two buffer arrangements. In one, duty and period each have their own buffer. In the other, a single shared buffer carries a target bit. The block flags the start of each period and shows whether an update is still waiting. It also reports whether the channel is running. A requested stop completes only when the current period ends.

Top module: `pwm_chan_core`

## Requirements
- R1: While running, the period counter advances once every 2^P clock cycles, where P is `cfg_pre`. Any `cfg_pre` value above 10 acts as 10. P is captured when the channel starts and is held for the whole run.
- R2: A period lasts max(period count, 1) count steps. `period_start` is high for the first clock cycle of every period, including the first period after a start. When `chan_en` is seen high at a clock edge while the channel is stopped, `running` and `period_start` are both high in the next cycle.
- R3: Within a period, the first duty-count steps are inactive and the remaining steps are active. A duty count of at least the period count keeps the output inactive for the whole period. A duty count of 0 keeps it active for the whole period.
- R4: When `cfg_pol` is 0, active is 1 and inactive is 0. When `cfg_pol` is 1, the levels are inverted. The polarity is captured at start, and later changes to `cfg_pol` while running have no effect. While the channel is stopped, `pwm_out` equals `cfg_pol`.
- R5: A `wr_buffered` strobe stores `wr_data` for the target given by `wr_tgt` (0 = duty, 1 = period). The stored value replaces the live count only at the next period boundary. `upd_pending` is high from the cycle after the write until the boundary that applies it.
- R6: With DUAL_UPD=1, duty and period have separate buffers. Both can be pending at once, and both are applied at the same boundary.
- R7: With DUAL_UPD=0, one buffer is shared. The last buffered write before the boundary wins, and that includes its target.
- R8: A `wr_direct` strobe loads `wr_data` into the live count selected by `wr_tgt` at once, but only while the channel is stopped. While the channel is running, the strobe is ignored.
- R9: When `chan_en` drops while the channel is running, `running` stays high until the current period ends. At that boundary `running` goes low, `period_start` is not raised, and `pwm_out` returns to the inactive level.
- R10: If a buffered write lands in the same cycle as a period boundary, the value that was already pending is applied. The new value stays pending for the following boundary.
- R11: Starting the channel applies any pending buffered values before the first period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en | input | 1 | Run request; dropping it stops the channel at the end of the period |
| cfg_pre | input | PRE_W | Prescaler exponent, captured at start |
| cfg_pol | input | 1 | Polarity: 0 active high, 1 active low |
| wr_data | input | CNT_W | Value for a direct or buffered write |
| wr_tgt | input | 1 | Write target: 0 duty, 1 period |
| wr_direct | input | 1 | Immediate load strobe, honoured only while stopped |
| wr_buffered | input | 1 | Update buffer write strobe |
| pwm_out | output | 1 | Waveform |
| period_start | output | 1 | One-cycle flag in the first cycle of each period |
| upd_pending | output | 1 | A buffered value waits for a boundary |
| running | output | 1 | The channel is generating periods |

## Verification
The interesting collision is a buffered write that arrives in the very cycle in which the counter wraps. In that cycle the block both applies the buffer and loads it again. The bench counts cycles from an observed period start so that the strobe lands exactly on the wrap edge. It then checks three things: `upd_pending` is still high, the following period uses the older value, and the period after that uses the newer one. Random strobes with short periods hit the same cycle again and again, and a cycle-level reference model in the bench judges each of those cases.

// File: rtl/pwm_pkg.sv
// Package: shared types for the PWM channel core.
// Assumes: a write target is a single bit (0 = duty, 1 = period).
package pwm_pkg;

    typedef enum logic {
        TGT_DUTY   = 1'b0,
        TGT_PERIOD = 1'b1
    } upd_tgt_e;

endpackage

// File: rtl/pwm_prescaler.sv
// Module: pwm_prescaler
// Produces a one-cycle count tick every 2^pre_sel clocks while run is high.
// Assumes: pre_sel has already been limited to at most DIV_W by the caller.
module pwm_prescaler #(
    parameter int PRE_W = 4,
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] pre_sel,
    output logic             tick
);

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] div_lim;

    // Last divider value: low pre_sel bits set.
    always_comb div_lim = ~({DIV_W{1'b1}} << pre_sel);

    // Tick when the divider reaches its limit.
    always_comb tick = run && (div_cnt == div_lim);

    // Divider: cleared while stopped and on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_shadow_regs.sv
// Module: pwm_shadow_regs
// Holds the live duty and period counts and their update buffers.
// DUAL_UPD=1 builds one buffer per count.
// DUAL_UPD=0 builds one shared buffer with a target bit.
// Assumes: apply is high exactly at a period boundary or at a channel start.
module pwm_shadow_regs
    import pwm_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter bit DUAL_UPD = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             apply,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             wr_tgt,
    input  logic             wr_direct,
    input  logic             wr_buffered,
    output logic [CNT_W-1:0] duty_act,
    output logic [CNT_W-1:0] per_act,
    output logic             pending
);

    upd_tgt_e         tgt;
    logic             take_duty;
    logic             take_per;
    logic [CNT_W-1:0] src_duty;
    logic [CNT_W-1:0] src_per;
    logic             dir_duty;
    logic             dir_per;

    // Decode the write target and the direct-load qualifiers.
    always_comb begin
        tgt      = upd_tgt_e'(wr_tgt);
        dir_duty = wr_direct && !running && (tgt == TGT_DUTY);
        dir_per  = wr_direct && !running && (tgt == TGT_PERIOD);
    end

    generate
        if (DUAL_UPD) begin : g_dual
            logic [CNT_W-1:0] buf_duty;
            logic [CNT_W-1:0] buf_per;
            logic             pend_duty;
            logic             pend_per;
            logic             wr_duty_buf;
            logic             wr_per_buf;

            // Per-target buffer write strobes.
            always_comb begin
                wr_duty_buf = wr_buffered && (tgt == TGT_DUTY);
                wr_per_buf  = wr_buffered && (tgt == TGT_PERIOD);
            end

            // Separate buffers; a write in an apply cycle stays pending.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    buf_duty  <= '0;
                    buf_per   <= '0;
                    pend_duty <= 1'b0;
                    pend_per  <= 1'b0;
                end else begin
                    if (wr_duty_buf) buf_duty <= wr_data;
                    if (wr_per_buf)  buf_per  <= wr_data;
                    pend_duty <= (pend_duty && !apply) || wr_duty_buf;
                    pend_per  <= (pend_per  && !apply) || wr_per_buf;
                end
            end

            // Route the buffers toward the live counts.
            always_comb begin
                take_duty = apply && pend_duty;
                take_per  = apply && pend_per;
                src_duty  = buf_duty;
                src_per   = buf_per;
                pending   = pend_duty || pend_per;
            end
        end else begin : g_shared
            logic [CNT_W-1:0] buf_val;
            upd_tgt_e         buf_tgt;
            logic             pend_any;

            // Shared buffer: the last write sets both value and target.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    buf_val  <= '0;
                    buf_tgt  <= TGT_DUTY;
                    pend_any <= 1'b0;
                end else begin
                    if (wr_buffered) begin
                        buf_val <= wr_data;
                        buf_tgt <= tgt;
                    end
                    pend_any <= (pend_any && !apply) || wr_buffered;
                end
            end

            // Route the shared buffer to its recorded target.
            always_comb begin
                take_duty = apply && pend_any && (buf_tgt == TGT_DUTY);
                take_per  = apply && pend_any && (buf_tgt == TGT_PERIOD);
                src_duty  = buf_val;
                src_per   = buf_val;
                pending   = pend_any;
            end
        end
    endgenerate

    // Live counts: buffered apply has priority over a direct load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_act <= '0;
            per_act  <= '0;
        end else begin
            if (take_duty)     duty_act <= src_duty;
            else if (dir_duty) duty_act <= wr_data;
            if (take_per)      per_act  <= src_per;
            else if (dir_per)  per_act  <= wr_data;
        end
    end

endmodule

// File: rtl/pwm_period_ctrl.sv
// Module: pwm_period_ctrl
// Run/stop sequencing, the period counter and the period-start flag.
// It also captures the prescaler and polarity settings at start.
// Assumes: tick is high only while running is high.
module pwm_period_ctrl #(
    parameter int CNT_W   = 16,
    parameter int PRE_W   = 4,
    parameter int PRE_MAX = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_en,
    input  logic [PRE_W-1:0] cfg_pre,
    input  logic             cfg_pol,
    input  logic             tick,
    input  logic [CNT_W-1:0] per_act,
    output logic             running,
    output logic             period_start,
    output logic             apply,
    output logic [CNT_W-1:0] cnt,
    output logic [PRE_W-1:0] pre_r,
    output logic             pol_r
);

    localparam logic [PRE_W-1:0] PRE_LIM = PRE_W'(PRE_MAX);
    localparam logic [CNT_W:0]   ONE_EXT = (CNT_W+1)'(1);

    logic start;
    logic wrap;

    // Start request, last count step of the period, and the buffer apply pulse.
    always_comb begin
        start = !running && chan_en;
        wrap  = tick && (({1'b0, cnt} + ONE_EXT) >= {1'b0, per_act});
        apply = start || (running && wrap);
    end

    // Run state, counter, period flag and captured settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running      <= 1'b0;
            period_start <= 1'b0;
            cnt          <= '0;
            pre_r        <= '0;
            pol_r        <= 1'b0;
        end else begin
            period_start <= 1'b0;
            if (start) begin
                running      <= 1'b1;
                period_start <= 1'b1;
                cnt          <= '0;
                pre_r        <= (cfg_pre > PRE_LIM) ? PRE_LIM : cfg_pre;
                pol_r        <= cfg_pol;
            end else if (running && tick) begin
                if (wrap) begin
                    cnt <= '0;
                    if (chan_en) begin
                        period_start <= 1'b1;
                    end else begin
                        running <= 1'b0;
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pwm_chan_core.sv
// Module: pwm_chan_core (top)
// One PWM channel with double-buffered duty and period counts.
// Assumes: a synchronous active-low reset, and that the configuration inputs
// are driven by registers in the same clock domain.
module pwm_chan_core #(
    parameter int CNT_W    = 16,
    parameter int PRE_W    = 4,
    parameter int PRE_MAX  = 10,
    parameter bit DUAL_UPD = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_en,
    input  logic [PRE_W-1:0] cfg_pre,
    input  logic             cfg_pol,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             wr_tgt,
    input  logic             wr_direct,
    input  logic             wr_buffered,
    output logic             pwm_out,
    output logic             period_start,
    output logic             upd_pending,
    output logic             running
);

    localparam int DIV_W = PRE_MAX;

    logic             tick;
    logic             apply;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] duty_act;
    logic [CNT_W-1:0] per_act;
    logic [PRE_W-1:0] pre_r;
    logic             pol_r;

    pwm_prescaler #(
        .PRE_W (PRE_W),
        .DIV_W (DIV_W)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (running),
        .pre_sel (pre_r),
        .tick    (tick)
    );

    pwm_period_ctrl #(
        .CNT_W   (CNT_W),
        .PRE_W   (PRE_W),
        .PRE_MAX (PRE_MAX)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .chan_en      (chan_en),
        .cfg_pre      (cfg_pre),
        .cfg_pol      (cfg_pol),
        .tick         (tick),
        .per_act      (per_act),
        .running      (running),
        .period_start (period_start),
        .apply        (apply),
        .cnt          (cnt),
        .pre_r        (pre_r),
        .pol_r        (pol_r)
    );

    pwm_shadow_regs #(
        .CNT_W    (CNT_W),
        .DUAL_UPD (DUAL_UPD)
    ) u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .running     (running),
        .apply       (apply),
        .wr_data     (wr_data),
        .wr_tgt      (wr_tgt),
        .wr_direct   (wr_direct),
        .wr_buffered (wr_buffered),
        .duty_act    (duty_act),
        .per_act     (per_act),
        .pending     (upd_pending)
    );

    // Waveform: active once the count reaches the duty count; idle level is cfg_pol.
    always_comb pwm_out = running ? ((cnt >= duty_act) ^ pol_r) : cfg_pol;

endmodule

// File: rtl/pwm_chan_core_chk.sv
// Module: pwm_chan_core_chk
// Assertion checker attached to every pwm_chan_core instance through a bind.
module pwm_chan_core_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             chan_en,
    input logic             cfg_pol,
    input logic             wr_buffered,
    input logic             pwm_out,
    input logic             period_start,
    input logic             upd_pending,
    input logic             running,
    input logic [CNT_W-1:0] duty_act,
    input logic [CNT_W-1:0] per_act,
    input logic             pol_r
);

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (pwm_out == cfg_pol)); // R4

    AST_PERIOD_OPENS_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (period_start && (duty_act != '0)) |-> (pwm_out == pol_r)); // R3

    AST_LIVE_COUNTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !period_start) |-> ($stable(duty_act) && $stable(per_act))); // R5

    AST_PENDING_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (period_start && !$past(wr_buffered)) |-> !upd_pending); // R10

    AST_STOP_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> !$past(chan_en)); // R9

    AST_START_WHILE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |-> running); // R2

endmodule

bind pwm_chan_core pwm_chan_core_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .chan_en      (chan_en),
    .cfg_pol      (cfg_pol),
    .wr_buffered  (wr_buffered),
    .pwm_out      (pwm_out),
    .period_start (period_start),
    .upd_pending  (upd_pending),
    .running      (running),
    .duty_act     (duty_act),
    .per_act      (per_act),
    .pol_r        (pol_r)
);

// File: tb/pwm_chan_core_tb.sv
module pwm_chan_core_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int PRE_W      = 4;

    logic             clk         = 1'b0;
    logic             rst_n       = 1'b0;
    logic             chan_en     = 1'b0;
    logic [PRE_W-1:0] cfg_pre     = '0;
    logic             cfg_pol     = 1'b0;
    logic [CNT_W-1:0] wr_data     = '0;
    logic             wr_tgt      = 1'b0;
    logic             wr_direct   = 1'b0;
    logic             wr_buffered = 1'b0;
    logic [1:0]       pwm_o, ps_o, pend_o, run_o;

    int    checks  = 0;
    int    errors  = 0;
    string cur_req = "R2";
    bit    done    = 1'b0;

    // Reference model state; index 0 = dual buffers, 1 = shared buffer.
    int m_cnt[2], m_pc[2], m_duty[2], m_per[2], m_bd[2], m_bp[2], m_pre[2];
    bit m_run[2], m_ps[2], m_pol[2], m_pd[2], m_pp[2], m_bt[2];

    pwm_chan_core #(.CNT_W(CNT_W), .PRE_W(PRE_W), .DUAL_UPD(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .cfg_pre(cfg_pre),
        .cfg_pol(cfg_pol), .wr_data(wr_data), .wr_tgt(wr_tgt),
        .wr_direct(wr_direct), .wr_buffered(wr_buffered),
        .pwm_out(pwm_o[0]), .period_start(ps_o[0]),
        .upd_pending(pend_o[0]), .running(run_o[0]));

    pwm_chan_core #(.CNT_W(CNT_W), .PRE_W(PRE_W), .DUAL_UPD(1'b0)) u_dut_single (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .cfg_pre(cfg_pre),
        .cfg_pol(cfg_pol), .wr_data(wr_data), .wr_tgt(wr_tgt),
        .wr_direct(wr_direct), .wr_buffered(wr_buffered),
        .pwm_out(pwm_o[1]), .period_start(ps_o[1]),
        .upd_pending(pend_o[1]), .running(run_o[1]));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int clamp_pre(int p);
        return (p > 10) ? 10 : p;
    endfunction

    function automatic bit exp_pwm(int v);
        if (!m_run[v]) return cfg_pol;
        return (m_cnt[v] >= m_duty[v]) ^ m_pol[v];
    endfunction

    function automatic bit exp_pend(int v);
        return (v == 0) ? (m_pd[v] || m_pp[v]) : m_pd[v];
    endfunction

    // One clock of the model, built from the requirements.
    task automatic model_step(int v);
        int lim, nd, np, nbd, nbp, ncnt, npc, npre;
        bit tick, last, start, apply, npd, npp, nbt, nrun, nps, npol;
        bit dd, dp;
        lim   = (1 << m_pre[v]) - 1;
        tick  = m_run[v] && (m_pc[v] == lim);
        last  = tick && (m_cnt[v] + 1 >= m_per[v]);
        start = !m_run[v] && chan_en;
        apply = start || (m_run[v] && last);
        dd = wr_direct && !m_run[v] && (wr_tgt == 1'b0);
        dp = wr_direct && !m_run[v] && (wr_tgt == 1'b1);
        nd = m_duty[v]; np = m_per[v]; nbd = m_bd[v]; nbp = m_bp[v];
        npd = m_pd[v]; npp = m_pp[v]; nbt = m_bt[v];
        if (v == 0) begin
            if (apply && m_pd[v]) nd = m_bd[v]; else if (dd) nd = int'(wr_data);
            if (apply && m_pp[v]) np = m_bp[v]; else if (dp) np = int'(wr_data);
            if (wr_buffered && !wr_tgt) nbd = int'(wr_data);
            if (wr_buffered && wr_tgt)  nbp = int'(wr_data);
            npd = (m_pd[v] && !apply) || (wr_buffered && !wr_tgt);
            npp = (m_pp[v] && !apply) || (wr_buffered && wr_tgt);
        end else begin
            if (apply && m_pd[v] && !m_bt[v]) nd = m_bd[v]; else if (dd) nd = int'(wr_data);
            if (apply && m_pd[v] && m_bt[v])  np = m_bd[v]; else if (dp) np = int'(wr_data);
            if (wr_buffered) begin nbd = int'(wr_data); nbt = wr_tgt; end
            npd = (m_pd[v] && !apply) || wr_buffered;
        end
        nrun = m_run[v]; nps = 1'b0; ncnt = m_cnt[v]; npre = m_pre[v]; npol = m_pol[v];
        if (start) begin
            nrun = 1'b1; nps = 1'b1; ncnt = 0;
            npre = clamp_pre(int'(cfg_pre)); npol = cfg_pol;
        end else if (m_run[v] && tick) begin
            if (last) begin
                ncnt = 0;
                if (chan_en) nps = 1'b1; else nrun = 1'b0;
            end else begin
                ncnt = m_cnt[v] + 1;
            end
        end
        if (!m_run[v] || tick) npc = 0; else npc = m_pc[v] + 1;
        m_duty[v] = nd; m_per[v] = np; m_bd[v] = nbd; m_bp[v] = nbp;
        m_pd[v] = npd; m_pp[v] = npp; m_bt[v] = nbt; m_run[v] = nrun;
        m_ps[v] = nps; m_cnt[v] = ncnt; m_pre[v] = npre; m_pol[v] = npol;
        m_pc[v] = npc;
    endtask

    always @(posedge clk) begin
        for (int v = 0; v < 2; v++) begin
            if (!rst_n) begin
                m_cnt[v] = 0; m_pc[v] = 0; m_duty[v] = 0; m_per[v] = 0;
                m_bd[v] = 0; m_bp[v] = 0; m_pre[v] = 0; m_run[v] = 0;
                m_ps[v] = 0; m_pol[v] = 0; m_pd[v] = 0; m_pp[v] = 0; m_bt[v] = 0;
            end else begin
                model_step(v);
            end
        end
    end

    task automatic chk(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    task automatic compare();
        for (int v = 0; v < 2; v++) begin
            chk(pwm_o[v] == exp_pwm(v), {cur_req, " R3 R4 pwm_out"}, pwm_o[v], exp_pwm(v));
            chk(ps_o[v] == m_ps[v], {cur_req, " R2 period_start"}, ps_o[v], m_ps[v]);
            chk(run_o[v] == m_run[v], {cur_req, " R9 running"}, run_o[v], m_run[v]);
            chk(pend_o[v] == exp_pend(v), {cur_req, " R5 upd_pending"}, pend_o[v], exp_pend(v));
        end
    endtask

    task automatic cyc(int n = 1);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
            compare();
        end
    endtask

    task automatic wr(bit direct, bit tgt, int val);
        wr_data = CNT_W'(val); wr_tgt = tgt;
        wr_direct = direct; wr_buffered = !direct;
        cyc();
        wr_direct = 1'b0; wr_buffered = 1'b0;
    endtask

    task automatic wait_start();
        while (!ps_o[0]) cyc();
    endtask

    // Count high output cycles of both instances over len cycles.
    task automatic measure(int len, output int hi0, output int hi1);
        hi0 = 0; hi1 = 0;
        repeat (len) begin
            if (pwm_o[0]) hi0++;
            if (pwm_o[1]) hi1++;
            cyc();
        end
    endtask

    task automatic gap(output int g);
        g = 0;
        do begin cyc(); g++; end while (!ps_o[0]);
    endtask

    task automatic stop_wait();
        chan_en = 1'b0;
        while (run_o[0]) cyc();
    endtask

    initial begin
        int h0, h1, g;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(run_o == 2'b00, "R9 reset running", run_o, 0);
        chk(pwm_o == 2'b00, "R4 reset idle level", pwm_o, 0);
        chk(pend_o == 2'b00, "R5 reset pending", pend_o, 0);
        chk(ps_o == 2'b00, "R2 reset period_start", ps_o, 0);
        rst_n = 1'b1;
        cyc();

        // R8: direct loads while stopped
        cur_req = "R8";
        wr(1'b1, 1'b0, 2);
        wr(1'b1, 1'b1, 5);
        chan_en = 1'b1;
        cyc();
        chk(ps_o[0] && run_o[0], "R2 start flag", ps_o[0], 1);
        measure(5, h0, h1);
        chk(h0 == 3, "R3 active steps", h0, 3);
        wr(1'b1, 1'b0, 0);          // ignored while running
        wait_start();
        measure(5, h0, h1);
        chk(h0 == 3, "R8 direct ignored while running", h0, 3);

        // R5: buffered duty update
        cur_req = "R5";
        wr(1'b0, 1'b0, 4);
        chk(pend_o[0] == 1'b1, "R5 pending after write", pend_o[0], 1);
        wait_start();
        chk(pend_o[0] == 1'b0, "R5 pending cleared", pend_o[0], 0);
        measure(5, h0, h1);
        chk(h0 == 1, "R5 applied at boundary", h0, 1);

        // R3: duty above period
        cur_req = "R3";
        wr(1'b0, 1'b0, 7);
        wait_start();
        measure(5, h0, h1);
        chk(h0 == 0, "R3 duty >= period stays inactive", h0, 0);

        // R6 / R7: duty then period buffered in back-to-back cycles
        cur_req = "R6";
        wr(1'b0, 1'b0, 1);
        wr(1'b0, 1'b1, 8);
        wait_start();
        measure(8, h0, h1);
        chk(h0 == 7, "R6 dual buffers both applied", h0, 7);
        chk(h1 == 1, "R7 shared buffer last write wins", h1, 1);

        // R10: buffered write on the wrap edge
        cur_req = "R10";
        wr(1'b0, 1'b0, 6);
        wait_start();               // both instances now duty 6, period 8
        cyc(2);
        wr(1'b0, 1'b0, 5);
        cyc(4);
        wr(1'b0, 1'b0, 3);          // lands on the wrap edge
        chk(ps_o[0] == 1'b1, "R10 boundary reached", ps_o[0], 1);
        chk(pend_o[0] == 1'b1, "R10 new value still pending", pend_o[0], 1);
        measure(8, h0, h1);
        chk(h0 == 3, "R10 older value applied first", h0, 3);
        measure(8, h0, h1);
        chk(h0 == 5, "R10 newer value at next boundary", h0, 5);

        // R9: stop request completes at the period end
        cur_req = "R9";
        wait_start();
        chan_en = 1'b0;
        cyc(7);
        chk(run_o[0] == 1'b1, "R9 still running before end", run_o[0], 1);
        cyc();
        chk(run_o[0] == 1'b0, "R9 stopped at boundary", run_o[0], 0);
        chk(pwm_o[0] == 1'b0, "R9 inactive after stop", pwm_o[0], 0);

        // R4: inverted polarity, captured at start
        cur_req = "R4";
        cfg_pol = 1'b1;
        cyc();
        chk(pwm_o[0] == 1'b1, "R4 idle inverted level", pwm_o[0], 1);
        chan_en = 1'b1;
        wait_start();
        measure(8, h0, h1);
        chk(h0 == 3, "R4 inverted waveform", h0, 3);
        cfg_pol = 1'b0;
        measure(8, h0, h1);
        chk(h0 == 3, "R4 polarity change ignored while running", h0, 3);

        // R1: prescaler clamp
        cur_req = "R1";
        stop_wait();
        wr(1'b1, 1'b0, 0);
        wr(1'b1, 1'b1, 1);
        cfg_pre = 4'd15;
        chan_en = 1'b1;
        wait_start();
        gap(g);
        chk(g == 1024, "R1 prescaler limited to 10", g, 1024);

        // R11: pending value applied at start
        cur_req = "R11";
        stop_wait();
        cfg_pre = 4'd2;
        wr(1'b0, 1'b1, 2);
        chan_en = 1'b1;
        wait_start();
        gap(g);
        chk(g == 8, "R11 start applies pending period", g, 8);

        // Random phase
        cur_req = "R5 random";
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(63) == 0) chan_en = ~chan_en;
            if ($urandom_range(31) == 0) cfg_pol = ~cfg_pol;
            cfg_pre     = PRE_W'($urandom_range(1));
            wr_data     = CNT_W'($urandom_range(9));
            wr_tgt      = 1'($urandom_range(1));
            wr_direct   = ($urandom_range(7) == 0);
            wr_buffered = ($urandom_range(5) == 0);
            cyc();
        end
        wr_direct = 1'b0; wr_buffered = 1'b0;
        cyc(2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule